// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is a hardware master that loads a bitstream into a target FPGA over a byte-wide slave parallel port. A single start pulse, together with a total byte count, starts a full configuration sequence. The block pulses the target's program line and waits for the target to clear its configuration memory. It then waits for the target to report that it is ready. Next it selects the port for writing and waits out a settling period. After that it clocks the bitstream bytes in one at a time. The bytes arrive from an upstream valid/ready byte stream.

While the bytes stream in, the block watches the target's status lines. The init line reports a configuration error. The busy line throttles the byte rate when busy checking is enabled. The done line ends the stream early with success. Each wait on the target is bounded by a timeout counted in ticks of a prescaled clock. A failure returns every pin to idle and latches an error code naming the phase that failed. For a mid-stream error, the block also records how many bytes had been clocked. The failure stays latched until software clears it. All target status inputs pass through a two-flop synchronizer. All target control outputs come straight from registers.

Top module: `cfgld_top`

## Requirements
- R1: Out of reset, program, chip-select, write and the configuration clock are all low. The `busy`, `ok` and `fail` outputs are low, `err_code` is 0 and `s_ready` is low.
- R2: An accepted start raises program and holds it for at least PROG_TICKS ticks. Program stays high until init is seen high. If init is not seen within INIT_TIMEOUT ticks after the hold, the run fails with `err_code` 1.
- R3: Program falls in the same cycle that the configuration clock goes high. After that the block waits for init to go low. If init is still high after INIT_TIMEOUT ticks, the run fails with `err_code` 2.
- R4: Chip-select and write rise only after init goes low, and never while program is high. The first byte is clocked no sooner than SETTLE_TICKS ticks after chip-select rises.
- R5: Each byte is taken with an `s_valid`/`s_ready` handshake and placed on `cfg_data`. The clock is driven low for one cycle, then high. The data does not change on the rising edge, and bytes go out in stream order.
- R6: If done is high before a byte is due, streaming stops and no further bytes are requested. The run then ends with success.
- R7: If init is high before a byte is due, the run fails with `err_code` 3. `err_offset` then equals the number of bytes already clocked.
- R8: With CHECK_BUSY set, after each clock pulse the block waits for busy to go low before the next byte. If busy stays high for BUSY_TIMEOUT ticks, the run fails with `err_code` 4.
- R9: After the last byte, chip-select and write fall. Success (`ok`) requires done high and init low within DONE_TIMEOUT ticks; otherwise the run fails with `err_code` 5. `ok` and `fail` are never high together.
- R10: On any failure all four control lines go low in the same cycle that `fail` rises. `fail` and `err_code` then hold, and start pulses are ignored until `clear` is pulsed; `clear` returns both to 0.
- R11: When neither done nor init interrupts the stream, exactly `byte_count` bytes are clocked. A count of zero clocks no bytes and goes straight to the completion check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a configuration |
| byte_count | input | CNT_W | Bitstream length in bytes, sampled with start |
| clear | input | 1 | Clears the sticky success and failure status |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte available |
| s_ready | output | 1 | Loader takes the stream byte this cycle |
| cfg_prog | output | 1 | Program request to target, high = asserted |
| cfg_sel | output | 1 | Chip-select to target, high = asserted |
| cfg_wr | output | 1 | Write enable to target, high = asserted |
| cfg_clk | output | 1 | Configuration clock to target |
| cfg_data | output | 8 | Byte bus to target |
| tgt_init | input | 1 | Target init status, high = asserted (clearing or error) |
| tgt_busy | input | 1 | Target busy status, high = busy |
| tgt_done | input | 1 | Target done status, high = configured |
| busy | output | 1 | A configuration run is in progress |
| ok | output | 1 | Last run succeeded (sticky until clear or next start) |
| fail | output | 1 | Last run failed (sticky until clear) |
| err_code | output | 3 | Failing phase: 0 none, 1 init-assert timeout, 2 ready timeout, 3 mid-stream error, 4 busy timeout, 5 completion timeout |
| err_offset | output | CNT_W | Bytes clocked when the failure was latched |

## Verification
A wrong phase state in this block shows up within a few cycles on the four control pins. Typical symptoms are chip-select rising while program is still high, a clock pulse outside the streaming window, or a handshake offered with the port not selected. A wrong byte or tick count does not show until the run ends, and it shows as a captured byte count or payload that differs from what the stream held. A timeout in the wrong phase shows as an `err_code` that does not name the phase the target model stalled. A broken sticky path shows up as soon as a start pulse that should be ignored instead raises program.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    // Loader sequencing states
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_PROG   = 4'd1,
        ST_WINIT  = 4'd2,
        ST_WREADY = 4'd3,
        ST_SETTLE = 4'd4,
        ST_FETCH  = 4'd5,
        ST_CLO    = 4'd6,
        ST_CHI    = 4'd7,
        ST_BUSYW  = 4'd8,
        ST_FIN    = 4'd9
    } cfg_state_e;

    // Failure codes, visible on err_code
    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_INIT_TO  = 3'd1,
        ERR_READY_TO = 3'd2,
        ERR_STREAM   = 3'd3,
        ERR_BUSY_TO  = 3'd4,
        ERR_DONE_TO  = 3'd5
    } cfg_err_e;

    // Target control pin levels (high = asserted)
    typedef struct packed {
        logic prog;
        logic sel;
        logic wr;
        logic cclk;
    } pins_t;

    // Cycles the clock stays high after each pulse; covers the status synchronizer latency
    localparam int HOLD_CYC = 4;

    function automatic pins_t pins_for(cfg_state_e s);
        pins_t p;
        p = '0;
        case (s)
            ST_PROG, ST_WINIT: p.prog = 1'b1;
            ST_WREADY, ST_FIN: p.cclk = 1'b1;
            ST_SETTLE, ST_FETCH, ST_CHI, ST_BUSYW: begin
                p.sel  = 1'b1;
                p.wr   = 1'b1;
                p.cclk = 1'b1;
            end
            ST_CLO: begin
                p.sel = 1'b1;
                p.wr  = 1'b1;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/cfgld_ticker.sv
module cfgld_ticker #(
    parameter int DIV = 125,
    parameter int W   = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] ticks
);
    logic step;

    generate
        if (DIV <= 1) begin : g_direct
            assign step = 1'b1;
        end else begin : g_pre
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || clr)          pre_q <= '0;
                else if (pre_q == LAST)  pre_q <= '0;
                else                     pre_q <= pre_q + 1'b1;
            end
            assign step = (pre_q == LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr)              ticks <= '0;
        else if (step && !(&ticks))  ticks <= ticks + 1'b1;
    end
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top #(
    parameter int CNT_W         = 24,
    parameter int TICK_W        = 32,
    parameter int TICK_DIV      = 125,
    parameter int PROG_TICKS    = 10,
    parameter int INIT_TIMEOUT  = 500000,
    parameter int SETTLE_TICKS  = 10000,
    parameter int BUSY_TIMEOUT  = 5000,
    parameter int DONE_TIMEOUT  = 200000,
    parameter bit CHECK_BUSY    = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             clear,
    input  logic [7:0]       s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             cfg_prog,
    output logic             cfg_sel,
    output logic             cfg_wr,
    output logic             cfg_clk,
    output logic [7:0]       cfg_data,
    input  logic             tgt_init,
    input  logic             tgt_busy,
    input  logic             tgt_done,
    output logic             busy,
    output logic             ok,
    output logic             fail,
    output logic [2:0]       err_code,
    output logic [CNT_W-1:0] err_offset
);
    import cfgld_pkg::*;

    localparam logic [TICK_W-1:0] LIM_PROG   = TICK_W'(PROG_TICKS);
    localparam logic [TICK_W-1:0] LIM_INIT   = TICK_W'(INIT_TIMEOUT);
    localparam logic [TICK_W-1:0] LIM_SETTLE = TICK_W'(SETTLE_TICKS);
    localparam logic [TICK_W-1:0] LIM_BUSY   = TICK_W'(BUSY_TIMEOUT);
    localparam logic [TICK_W-1:0] LIM_DONE   = TICK_W'(DONE_TIMEOUT);
    localparam logic [2:0]        PH_LAST    = 3'(HOLD_CYC - 1);
    localparam cfg_state_e        AFTER_HI   = CHECK_BUSY ? ST_BUSYW : ST_FETCH;

    cfg_state_e        state_q, state_n;
    cfg_err_e          err_q, err_n;
    pins_t             pins_q;
    logic [2:0]        stat_s;
    logic              init_s, busy_s, done_s;
    logic [TICK_W-1:0] ticks;
    logic [2:0]        ph_q;
    logic [CNT_W-1:0]  total_q, sent_q, off_q;
    logic [7:0]        data_q;
    logic              ok_q, fail_q;
    logic              go, take, fail_set, ok_set, more;

    cfgld_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({tgt_init, tgt_busy, tgt_done}),
        .sync_o  (stat_s)
    );
    assign init_s = stat_s[2];
    assign busy_s = stat_s[1];
    assign done_s = stat_s[0];

    cfgld_ticker #(.DIV(TICK_DIV), .W(TICK_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clr   (state_n != state_q),
        .ticks (ticks)
    );

    assign go      = (state_q == ST_IDLE) && start && !fail_q;
    assign more    = (sent_q != total_q);
    assign s_ready = (state_q == ST_FETCH) && !done_s && !init_s && more;
    assign take    = s_ready && s_valid;

    always_comb begin
        state_n  = state_q;
        err_n    = ERR_NONE;
        fail_set = 1'b0;
        ok_set   = 1'b0;
        case (state_q)
            ST_IDLE:   if (go) state_n = ST_PROG;
            ST_PROG:   if (ticks >= LIM_PROG) state_n = ST_WINIT;
            ST_WINIT: begin
                if (init_s)                 state_n = ST_WREADY;
                else if (ticks >= LIM_INIT) begin fail_set = 1'b1; err_n = ERR_INIT_TO; end
            end
            ST_WREADY: begin
                if (!init_s)                state_n = ST_SETTLE;
                else if (ticks >= LIM_INIT) begin fail_set = 1'b1; err_n = ERR_READY_TO; end
            end
            ST_SETTLE: if (ticks >= LIM_SETTLE) state_n = ST_FETCH;
            ST_FETCH: begin
                if (done_s)       state_n = ST_FIN;
                else if (init_s)  begin fail_set = 1'b1; err_n = ERR_STREAM; end
                else if (!more)   state_n = ST_FIN;
                else if (s_valid) state_n = ST_CLO;
            end
            ST_CLO:    state_n = ST_CHI;
            ST_CHI:    if (ph_q == PH_LAST) state_n = AFTER_HI;
            ST_BUSYW: begin
                if (!busy_s)                state_n = ST_FETCH;
                else if (ticks >= LIM_BUSY) begin fail_set = 1'b1; err_n = ERR_BUSY_TO; end
            end
            ST_FIN: begin
                if (done_s && !init_s)      begin ok_set = 1'b1; state_n = ST_IDLE; end
                else if (ticks >= LIM_DONE) begin fail_set = 1'b1; err_n = ERR_DONE_TO; end
            end
            default: state_n = ST_IDLE;
        endcase
        if (fail_set) state_n = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= '0;
            ph_q    <= '0;
            total_q <= '0;
            sent_q  <= '0;
            data_q  <= '0;
            ok_q    <= 1'b0;
            fail_q  <= 1'b0;
            err_q   <= ERR_NONE;
            off_q   <= '0;
        end else begin
            state_q <= state_n;
            pins_q  <= pins_for(state_n);
            ph_q    <= (state_n != state_q) ? 3'd0 : ph_q + 3'd1;
            if (go) begin
                total_q <= byte_count;
                sent_q  <= '0;
                ok_q    <= 1'b0;
            end
            if (take) begin
                data_q <= s_data;
                sent_q <= sent_q + 1'b1;
            end
            if (ok_set) ok_q <= 1'b1;
            if (fail_set) begin
                fail_q <= 1'b1;
                err_q  <= err_n;
                off_q  <= sent_q;
            end
            if (clear) begin
                ok_q   <= 1'b0;
                fail_q <= 1'b0;
                err_q  <= ERR_NONE;
                off_q  <= '0;
            end
        end
    end

    assign cfg_prog   = pins_q.prog;
    assign cfg_sel    = pins_q.sel;
    assign cfg_wr     = pins_q.wr;
    assign cfg_clk    = pins_q.cclk;
    assign cfg_data   = data_q;
    assign busy       = (state_q != ST_IDLE);
    assign ok         = ok_q;
    assign fail       = fail_q;
    assign err_code   = err_q;
    assign err_offset = off_q;
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       clear,
    input logic       s_ready,
    input logic       cfg_prog,
    input logic       cfg_sel,
    input logic       cfg_wr,
    input logic       cfg_clk,
    input logic [7:0] cfg_data,
    input logic       busy,
    input logic       ok,
    input logic       fail,
    input logic [2:0] err_code
);
    // R10: failure leaves every control line idle
    p_fail_idle_r10: assert property (@(posedge clk) disable iff (rst)
        fail |-> (!cfg_prog && !cfg_sel && !cfg_wr && !cfg_clk));

    // R10: failure status and code hold until clear
    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> (fail && $stable(err_code)));

    // R10: a start during a latched failure does not begin a run
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (fail && start && !clear) |=> !busy);

    // R4: the port is never selected while program is asserted
    p_sel_not_prog_r4: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sel && cfg_prog));

    // R5: data bus unchanged across each rising configuration clock edge
    p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_clk) && cfg_sel) |-> $stable(cfg_data));

    // R5: stream handshake only offered while streaming with the clock high
    p_ready_window_r5: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (cfg_sel && cfg_wr && cfg_clk && !cfg_prog));

    // R3: program release coincides with the clock going high
    p_prog_release_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(cfg_prog) && !fail) |-> cfg_clk);

    // R9: success and failure never reported together
    p_ok_fail_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(ok && fail));
endmodule

bind cfgld_top cfgld_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .clear    (clear),
    .s_ready  (s_ready),
    .cfg_prog (cfg_prog),
    .cfg_sel  (cfg_sel),
    .cfg_wr   (cfg_wr),
    .cfg_clk  (cfg_clk),
    .cfg_data (cfg_data),
    .busy     (busy),
    .ok       (ok),
    .fail     (fail),
    .err_code (err_code)
);

// File: tb/test_cfgld_top.sv
module test_cfgld_top;
    localparam int CNT_W = 24;
    localparam int DIV   = 4;
    localparam int PROGT = 3;
    localparam int SETT  = 5;

    localparam int M_NORMAL  = 0;
    localparam int M_STRETCH = 1;
    localparam int M_EARLY   = 2;
    localparam int M_MIDERR  = 3;
    localparam int M_STUCK   = 4;
    localparam int M_NODONE  = 5;
    localparam int M_NOINIT  = 6;
    localparam int M_NOREADY = 7;

    // {mode[3:0], gaps, count[7:0], k[7:0], exp_ok, exp_code[2:0], exp_bytes[7:0]}
    localparam int NV = 9;
    localparam logic [32:0] VECS [NV] = '{
        {4'd0, 1'b0, 8'd6, 8'd0, 1'b1, 3'd0, 8'd6},
        {4'd0, 1'b1, 8'd7, 8'd0, 1'b1, 3'd0, 8'd7},
        {4'd1, 1'b0, 8'd5, 8'd0, 1'b1, 3'd0, 8'd5},
        {4'd2, 1'b0, 8'd8, 8'd3, 1'b1, 3'd0, 8'd3},
        {4'd3, 1'b0, 8'd8, 8'd4, 1'b0, 3'd3, 8'd4},
        {4'd4, 1'b0, 8'd5, 8'd0, 1'b0, 3'd4, 8'd1},
        {4'd5, 1'b0, 8'd3, 8'd0, 1'b0, 3'd5, 8'd3},
        {4'd6, 1'b0, 8'd4, 8'd0, 1'b0, 3'd1, 8'd0},
        {4'd7, 1'b0, 8'd4, 8'd0, 1'b0, 3'd2, 8'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic clear = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [7:0] s_data;
    logic s_valid, s_ready;
    logic cfg_prog, cfg_sel, cfg_wr, cfg_clk;
    logic [7:0] cfg_data;
    logic tgt_init = 1'b0, tgt_busy = 1'b0, tgt_done = 1'b0;
    logic busy, ok, fail;
    logic [2:0] err_code;
    logic [CNT_W-1:0] err_offset;

    int checks = 0;
    int errors = 0;

    // Bench-side run controls
    int   mode = 0;
    int   kpar = 0;
    logic gaps = 1'b0;
    logic new_run = 1'b0;
    logic src_en = 1'b0;

    // Target model state
    int   cyc = 0;
    int   src_idx = 0;
    int   nrx = 0;
    int   hold_len = 0, prog_len = 0;
    int   cs_rise = 0, first_gap = 0;
    int   rel_cnt = 0, busy_left = 0;
    logic released = 1'b0;
    logic cclk_at_rel = 1'b0;
    logic prog_d = 1'b0, cclk_d = 1'b0, cs_d = 1'b0;
    logic [7:0] cap [0:31];

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 90) & 255);
    endfunction

    assign s_data  = pat(src_idx);
    assign s_valid = src_en && !(gaps && ((cyc % 3) == 1));

    cfgld_top #(
        .CNT_W(CNT_W), .TICK_W(32), .TICK_DIV(DIV), .PROG_TICKS(PROGT),
        .INIT_TIMEOUT(20), .SETTLE_TICKS(SETT), .BUSY_TIMEOUT(10),
        .DONE_TIMEOUT(15), .CHECK_BUSY(1'b1)
    ) i_cfgld_top (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count), .clear(clear),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .cfg_prog(cfg_prog), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_clk(cfg_clk),
        .cfg_data(cfg_data), .tgt_init(tgt_init), .tgt_busy(tgt_busy), .tgt_done(tgt_done),
        .busy(busy), .ok(ok), .fail(fail), .err_code(err_code), .err_offset(err_offset)
    );

    // Behavioural target and stream source
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        prog_d <= cfg_prog;
        cclk_d <= cfg_clk;
        cs_d   <= cfg_sel;
        if (new_run)                  src_idx <= 0;
        else if (s_valid && s_ready)  src_idx <= src_idx + 1;
        if (cfg_prog && !prog_d) begin
            tgt_init <= 1'b0; tgt_done <= 1'b0; tgt_busy <= 1'b0;
            nrx <= 0; hold_len <= 1; rel_cnt <= 0; released <= 1'b0; busy_left <= 0;
        end else begin
            if (cfg_prog) begin
                hold_len <= hold_len + 1;
                if (mode != M_NOINIT) tgt_init <= 1'b1;
            end
            if (!cfg_prog && prog_d) begin
                cclk_at_rel <= cfg_clk;
                prog_len    <= hold_len;
            end
            if (!cfg_prog && !released && tgt_init && mode != M_NOREADY) begin
                rel_cnt <= rel_cnt + 1;
                if (rel_cnt == 7) begin tgt_init <= 1'b0; released <= 1'b1; end
            end
            if (cfg_sel && !cs_d) cs_rise <= cyc;
            if (busy_left > 0) begin
                busy_left <= busy_left - 1;
                if (busy_left == 1) tgt_busy <= 1'b0;
            end
            if (cfg_clk && !cclk_d && cfg_sel && cfg_wr) begin
                cap[nrx & 31] <= cfg_data;
                nrx <= nrx + 1;
                if (nrx == 0) first_gap <= cyc - cs_rise;
                if (mode == M_MIDERR && nrx + 1 == kpar) tgt_init <= 1'b1;
                if (mode == M_EARLY  && nrx + 1 == kpar) tgt_done <= 1'b1;
                if (mode == M_STRETCH) begin tgt_busy <= 1'b1; busy_left <= 4; end
                if (mode == M_STUCK) tgt_busy <= 1'b1;
            end
            if (!cfg_sel && cs_d && (mode == M_NORMAL || mode == M_STRETCH))
                tgt_done <= 1'b1;
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(int m);
        case (m)
            M_NORMAL:  return "R11";
            M_STRETCH: return "R8";
            M_EARLY:   return "R6";
            M_MIDERR:  return "R7";
            M_STUCK:   return "R8";
            M_NODONE:  return "R9";
            M_NOINIT:  return "R2";
            default:   return "R3";
        endcase
    endfunction

    task automatic launch(int m, int k, logic g, int n);
        @(negedge clk);
        clear = 1'b1; new_run = 1'b1; mode = m; kpar = k; gaps = g; src_en = 1'b1;
        @(negedge clk);
        clear = 1'b0; new_run = 1'b0; start = 1'b1; byte_count = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int t;
        t = 0;
        while (!(ok || fail) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 5000, req, "run completion timed out", t, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk({cfg_prog, cfg_sel, cfg_wr, cfg_clk} == 4'b0, "R1", "control pins",
            {cfg_prog, cfg_sel, cfg_wr, cfg_clk}, 0);
        chk({busy, ok, fail, s_ready} == 4'b0 && err_code == 3'd0, "R1", "status",
            {busy, ok, fail, s_ready, err_code}, 0);

        for (int v = 0; v < NV; v++) begin
            int m, n, k, eb, ec, bad;
            logic eo;
            m  = int'(VECS[v][32:29]);
            n  = int'(VECS[v][27:20]);
            k  = int'(VECS[v][19:12]);
            eo = VECS[v][11];
            ec = int'(VECS[v][10:8]);
            eb = int'(VECS[v][7:0]);
            launch(m, k, VECS[v][28], n);
            wait_end(tag_for(m));
            @(negedge clk);
            chk(ok == eo && fail == !eo, tag_for(m), "outcome ok", ok, eo);
            chk(err_code == 3'(ec), tag_for(m), "err_code", err_code, ec);
            chk(nrx == eb, "R11", "bytes clocked", nrx, eb);
            bad = 0;
            for (int i = 0; i < eb; i++) if (cap[i] !== pat(i)) bad++;
            chk(bad == 0, "R5", "payload mismatches", bad, 0);
            chk({cfg_prog, cfg_sel, cfg_wr} == 3'b0, "R9", "pins after run",
                {cfg_prog, cfg_sel, cfg_wr}, 0);
            if (m == M_MIDERR)
                chk(err_offset == CNT_W'(k), "R7", "err_offset", err_offset, k);
            if (v == 0) begin
                chk(prog_len >= PROGT * DIV, "R2", "program hold cycles", prog_len, PROGT * DIV);
                chk(cclk_at_rel == 1'b1, "R3", "clock at program release", cclk_at_rel, 1);
                chk(first_gap >= SETT * DIV, "R4", "select-to-first-byte cycles", first_gap, SETT * DIV);
            end
        end

        // R10: start ignored while the failure is latched
        @(negedge clk);
        start = 1'b1; byte_count = CNT_W'(2);
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy == 1'b0 && cfg_prog == 1'b0, "R10", "run started during failure",
            {busy, cfg_prog}, 0);
        chk(fail == 1'b1 && err_code == 3'd2, "R10", "sticky failure code", err_code, 2);
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk(fail == 1'b0 && err_code == 3'd0, "R10", "clear releases status", {fail, err_code}, 0);

        // R11: zero-length bitstream
        launch(M_NORMAL, 0, 1'b0, 0);
        wait_end("R11");
        @(negedge clk);
        chk(ok == 1'b1 && fail == 1'b0, "R11", "zero count outcome", ok, 1);
        chk(nrx == 0, "R11", "zero count bytes clocked", nrx, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule